// File: doc/BRIEF.md
# Windowed Watchdog Counter Core

This block is one watchdog channel. A programmable prescaler divides the clock into tick pulses, and each tick decrements a down-counter that was loaded with a reload value. When the counter has counted through zero, the block emits a one-cycle expiry pulse and starts the count again from the reload value. Software keeps the channel quiet by sending a one-cycle service strobe, which reloads the counter. Optionally, the service strobe is honoured only late in the count, when the counter has fallen to or below a threshold. A strobe that comes too early raises a separate one-cycle early-service pulse and leaves the count alone.

A neighbouring register block drives the configuration inputs as levels. These are the divider value, the reload value, the threshold, an enable and a lock. The register block also forwards the service strobe. The expiry and early-service pulses go to an event/mask block. Once the lock is set, it stays set until reset. From then on, the channel cannot be switched off, and the stored divider, reload and threshold values no longer follow their inputs. Threshold checking and lock support are build-time choices. The counter width and the divider width are parameters, each from 1 to 32 bits.

Top module: `wdog_core`

## Requirements
- R1: After reset, both event outputs are low, and all three status outputs (enabled, locked, in-window) are low.
- R2: If the enable input is high in a cycle where the channel is disabled, the channel becomes enabled at the next clock edge, and the counter loads the stored reload value T. With stored divider value P, the first expiry pulse is high in the (T+1)*(P+1)-th cycle after that edge, where the cycle right after the edge counts as the 1st.
- R3: After each expiry, the counter reloads by itself. Expiry pulses then recur every (T+1)*(P+1) cycles, each high for exactly one cycle.
- R4: A service strobe is accepted while the counter is at or below the stored threshold W. An accepted strobe reloads the counter and restarts the divider from zero. The next expiry is high (T+1)*(P+1) cycles after the cycle in which the strobe was high.
- R5: A service strobe that arrives while the counter is above W raises the early-service pulse in the same cycle. It does not reload the counter, so the expiry schedule stays unchanged.
- R6: The in-window status is high exactly when the channel is enabled and the counter is at or below W.
- R7: If an accepted strobe falls in the same cycle as the tick that would expire the counter (counter at zero), no expiry pulse is produced in that cycle, and the counter reloads as in R4.
- R8: While the channel is disabled, the divider and counter hold their values, service strobes are ignored, and no event pulse is produced.
- R9: Once the lock input has been high for one clock edge, the locked status stays high until reset, whatever the lock input does afterwards.
- R10: While locked, dropping the enable input does not disable an enabled channel.
- R11: While locked, changes to the divider, reload and threshold inputs are ignored. The channel keeps running with the values it held when the lock took effect.
- R12: The expiry pulse and the early-service pulse are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Enable level from the register block |
| cfgLock | input | 1 | Lock request (set-only) |
| cfgPrescale | input | PRE_W | Divider value P; a tick every P+1 cycles |
| cfgTimeout | input | CNT_W | Reload value T |
| cfgWindow | input | CNT_W | Service threshold W |
| kick | input | 1 | One-cycle service strobe |
| evtTimeout | output | 1 | One-cycle expiry pulse |
| evtViolation | output | 1 | One-cycle early-service pulse |
| stEnabled | output | 1 | Channel enabled |
| stLocked | output | 1 | Lock in force |
| stInWindow | output | 1 | Counter at or below threshold while enabled |

## Verification
Two events can land in the same cycle: a service strobe, and the final tick that takes the counter through zero. The bench places an accepted strobe exactly on that cycle. It then expects no expiry in that cycle and one full period later. A second collision is an early strobe on an ordinary tick cycle. Here the bench expects the early-service pulse and an unchanged expiry schedule. A scoreboard matches every event pulse by kind and by the exact cycle it appears in, and it flags any pulse that is missing or unexpected.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // strobes from the control to the datapath
  typedef struct packed {
    logic cfgTake;  // capture configuration inputs this cycle
    logic run;      // advance divider / counter
    logic reload;   // load counter from reload value, clear divider
  } wdStrobe_t;

endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRE_W    = 8,
  parameter bit WINDOWED = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        stb,
  input  logic [PRE_W-1:0] cfgPrescale,
  input  logic [CNT_W-1:0] cfgTimeout,
  input  logic [CNT_W-1:0] cfgWindow,
  output logic             tickHit,
  output logic             cntZero,
  output logic             inWin
);

  logic [PRE_W-1:0] preReg;
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] tmoReg;
  logic [CNT_W-1:0] winReg;
  logic [CNT_W-1:0] cnt;

  // stored configuration, frozen while cfgTake is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preReg <= '1;
      tmoReg <= '1;
      winReg <= '0;
    end else if (stb.cfgTake) begin
      preReg <= cfgPrescale;
      tmoReg <= cfgTimeout;
      winReg <= WINDOWED ? cfgWindow : '0;
    end
  end

  // divider and down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      cnt    <= '0;
    end else if (stb.reload) begin
      preCnt <= '0;
      cnt    <= tmoReg;
    end else if (stb.run) begin
      if (tickHit) begin
        preCnt <= '0;
        cnt    <= cnt - 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  assign tickHit = (preCnt == preReg);
  assign cntZero = (cnt == '0);

  generate
    if (WINDOWED) begin : g_win
      assign inWin = (cnt <= winReg);
    end else begin : g_nowin
      assign inWin = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter bit WINDOWED = 1'b1,
  parameter bit HAS_LOCK = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgEnable,
  input  logic      cfgLock,
  input  logic      kick,
  input  logic      tickHit,
  input  logic      cntZero,
  input  logic      inWin,
  output wdStrobe_t stb,
  output logic      enabled,
  output logic      locked,
  output logic      evtTimeout,
  output logic      evtViolation
);

  logic enRise;
  logic kickAct;
  logic kickOk;
  logic expire;

  assign enRise  = cfgEnable & ~enabled;
  assign kickAct = kick & enabled;
  assign kickOk  = kickAct & inWin;
  // an accepted kick on the final tick wins over the expiry
  assign expire  = enabled & tickHit & cntZero & ~kickOk;

  assign evtTimeout   = expire;
  assign evtViolation = WINDOWED ? (kickAct & ~inWin) : 1'b0;

  assign stb.cfgTake = ~locked;
  assign stb.run     = enabled;
  assign stb.reload  = enRise | kickOk | expire;

  // enable: a drop is ignored once locked
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabled <= 1'b0;
    end else if (locked) begin
      enabled <= enabled | cfgEnable;
    end else begin
      enabled <= cfgEnable;
    end
  end

  generate
    if (HAS_LOCK) begin : g_lock
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          locked <= 1'b0;
        end else if (cfgLock) begin
          locked <= 1'b1;
        end
      end
    end else begin : g_nolock
      assign locked = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRE_W    = 8,
  parameter bit WINDOWED = 1'b1,
  parameter bit HAS_LOCK = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic             cfgLock,
  input  logic [PRE_W-1:0] cfgPrescale,
  input  logic [CNT_W-1:0] cfgTimeout,
  input  logic [CNT_W-1:0] cfgWindow,
  input  logic             kick,
  output logic             evtTimeout,
  output logic             evtViolation,
  output logic             stEnabled,
  output logic             stLocked,
  output logic             stInWindow
);

  wdStrobe_t stb;
  logic      tickHit;
  logic      cntZero;
  logic      inWin;

  wdog_ctrl #(
    .WINDOWED(WINDOWED),
    .HAS_LOCK(HAS_LOCK)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgEnable   (cfgEnable),
    .cfgLock     (cfgLock),
    .kick        (kick),
    .tickHit     (tickHit),
    .cntZero     (cntZero),
    .inWin       (inWin),
    .stb         (stb),
    .enabled     (stEnabled),
    .locked      (stLocked),
    .evtTimeout  (evtTimeout),
    .evtViolation(evtViolation)
  );

  wdog_datapath #(
    .CNT_W   (CNT_W),
    .PRE_W   (PRE_W),
    .WINDOWED(WINDOWED)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cfgPrescale(cfgPrescale),
    .cfgTimeout (cfgTimeout),
    .cfgWindow  (cfgWindow),
    .tickHit    (tickHit),
    .cntZero    (cntZero),
    .inWin      (inWin)
  );

  assign stInWindow = WINDOWED ? (stEnabled & inWin) : 1'b0;

endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk (
  input logic clk,
  input logic rstN,
  input logic evtTimeout,
  input logic evtViolation,
  input logic stEnabled,
  input logic stLocked,
  input logic stInWindow
);

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(evtTimeout && evtViolation)); // R12

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    stLocked |=> stLocked); // R9

  AST_LOCK_HOLDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (stLocked && stEnabled) |=> stEnabled); // R10

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (evtTimeout || evtViolation) |-> stEnabled); // R8

  AST_EARLY_OUTSIDE: assert property (@(posedge clk) disable iff (!rstN)
    evtViolation |-> !stInWindow); // R5

endmodule

bind wdog_core wdog_core_chk u_chk (.*);

// File: tb/wdog_core_bench.sv
module wdog_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int PW = 8;

  typedef struct {
    int    cyc;
    int    kind;   // 0 expiry, 1 early-service
    string req;
  } item_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgEnable = 1'b0;
  logic          cfgLock = 1'b0;
  logic [PW-1:0] cfgPrescale = '0;
  logic [CW-1:0] cfgTimeout = '0;
  logic [CW-1:0] cfgWindow = '0;
  logic          kick = 1'b0;
  logic          evtTimeout;
  logic          evtViolation;
  logic          stEnabled;
  logic          stLocked;
  logic          stInWindow;

  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  item_t sbQ[$];

  wdog_core #(.CNT_W(CW), .PRE_W(PW)) u_wdog_core (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgLock(cfgLock),
    .cfgPrescale(cfgPrescale), .cfgTimeout(cfgTimeout), .cfgWindow(cfgWindow),
    .kick(kick), .evtTimeout(evtTimeout), .evtViolation(evtViolation),
    .stEnabled(stEnabled), .stLocked(stLocked), .stInWindow(stInWindow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expectEvt(input int c, input int kind, input string req);
    item_t it;
    it.cyc = c; it.kind = kind; it.req = req;
    sbQ.push_back(it);
  endtask

  // monitor: match each observed pulse against the scoreboard
  task automatic scoreEvent(input int kind);
    bit hit = 1'b0;
    for (int i = 0; i < sbQ.size(); i++) begin
      if (!hit && sbQ[i].cyc == cyc && sbQ[i].kind == kind) begin
        check(1'b1, sbQ[i].req, 1, 1);
        sbQ.delete(i);
        hit = 1'b1;
      end
    end
    if (!hit) check(1'b0, (kind == 0) ? "R3/R7 unexpected expiry" : "R5/R8 unexpected early-service", 1, 0);
  endtask

  always @(negedge clk) begin
    #1;
    if (rstN) begin
      if (evtTimeout) scoreEvent(0);
      if (evtViolation) scoreEvent(1);
      for (int i = sbQ.size() - 1; i >= 0; i--) begin
        if (sbQ[i].cyc < cyc) begin
          check(1'b0, {sbQ[i].req, " missed pulse"}, 0, sbQ[i].cyc);
          sbQ.delete(i);
        end
      end
    end
  end

  task automatic goTo(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic kickAt(input int n);
    goTo(n);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      finishRun();
    end
  end

  initial begin
    int b;
    int b2;
    int b3;
    int b4;
    cfgPrescale = 8'd3; cfgTimeout = 16'd2; cfgWindow = 16'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(evtTimeout == 1'b0, "R1 expiry low", evtTimeout, 0);
    check(evtViolation == 1'b0, "R1 early low", evtViolation, 0);
    check(stEnabled == 1'b0 && stLocked == 1'b0, "R1 status low", {stEnabled, stLocked}, 0);
    check(stInWindow == 1'b0, "R1 in-window low", stInWindow, 0);

    // P=3, T=2: period 12
    b = cyc + 2;
    goTo(b);
    cfgEnable = 1'b1;
    expectEvt(b + 12, 0, "R2 first expiry");
    expectEvt(b + 24, 0, "R3 auto reload");
    goTo(b + 1); #1;
    check(stEnabled == 1'b1, "R2 enabled", stEnabled, 1);
    goTo(b + 30);
    cfgEnable = 1'b0;
    goTo(b + 32); #1;
    check(stEnabled == 1'b0, "R8 disabled", stEnabled, 0);
    check(stInWindow == 1'b0, "R6 in-window off when disabled", stInWindow, 0);
    kickAt(b + 34);  // ignored: no pulse expected
    goTo(b + 80);

    // P=2, T=4, W=2: period 15
    cfgPrescale = 8'd2; cfgTimeout = 16'd4; cfgWindow = 16'd2;
    b2 = b + 82;
    goTo(b2);
    cfgEnable = 1'b1;
    expectEvt(b2 + 15, 0, "R2 expiry P2 T4");
    expectEvt(b2 + 2, 1, "R5 early kick");
    kickAt(b2 + 2);
    goTo(b2 + 21); #1;
    check(stInWindow == 1'b0, "R6 above threshold", stInWindow, 0);
    goTo(b2 + 22); #1;
    check(stInWindow == 1'b1, "R6 at threshold", stInWindow, 1);
    expectEvt(b2 + 38, 0, "R4 accepted kick restarts period");
    kickAt(b2 + 23);
    goTo(b2 + 45);
    cfgEnable = 1'b0;

    // P=1, T=9, W=3: period 20; kick on the expiring tick
    cfgPrescale = 8'd1; cfgTimeout = 16'd9; cfgWindow = 16'd3;
    b3 = b2 + 48;
    goTo(b3);
    cfgEnable = 1'b1;
    expectEvt(b3 + 40, 0, "R7 kick on final tick");
    expectEvt(b3 + 60, 0, "R3 period after R7");
    kickAt(b3 + 20);
    goTo(b3 + 65);
    cfgEnable = 1'b0;

    // lock while running
    b4 = b3 + 68;
    goTo(b4);
    cfgEnable = 1'b1;
    expectEvt(b4 + 20, 0, "R11 expiry with held config");
    expectEvt(b4 + 40, 0, "R10 expiry after enable drop");
    expectEvt(b4 + 60, 0, "R11 reload value held");
    goTo(b4 + 3);
    cfgLock = 1'b1;
    goTo(b4 + 5);
    cfgLock = 1'b0; cfgEnable = 1'b0;
    cfgTimeout = 16'd3; cfgPrescale = 8'd0; cfgWindow = 16'd9;
    goTo(b4 + 7); #1;
    check(stLocked == 1'b1, "R9 lock sticky", stLocked, 1);
    check(stEnabled == 1'b1, "R10 enable held", stEnabled, 1);
    expectEvt(b4 + 10, 1, "R11 threshold held");
    kickAt(b4 + 10);
    goTo(b4 + 70); #2;
    check(sbQ.size() == 0, "R3 scoreboard drained", sbQ.size(), 0);
    check(stLocked == 1'b1, "R9 lock still set", stLocked, 1);

    done = 1'b1;
    finishRun();
  end

endmodule